// File: doc/BRIEF.md
# Bit-Serial Tap Buffer with Coefficient Preload

This block feeds a bit-serial distributed-arithmetic FIR filter. It keeps one register row per filter tap: row 0 holds the newest sample and each lower row holds an older one. In every cycle it hands the table-address logic one bit of every stored sample, as one bit per tap on `tap_bits`. The bits go out least significant first, and `msb_flag` marks the cycle that carries the sign bit. After that cycle the rows move down by one tap if a new sample is waiting. The newest sample then enters row 0 and the oldest one is dropped.

The same rows serve first as a coefficient buffer. After reset the block is in loading mode. Each cycle with `coef_enable` high writes the shared `din` port into the next coefficient slot. The port is as wide as the larger of the sample width and the coefficient width. Once the last slot is written, `coef_full` pulses for one cycle and the block holds its contents, ignoring further writes. During the hold the table initializer reads any coefficient through `coef_sel`/`coef_rd`. When the initializer raises `table_ready`, the rows are cleared and the block starts serial operation.

The controller is a three-state machine:
- LOAD is the reset state, where coefficients are captured.
- HOLD keeps the coefficients frozen.
- RUN is the serial delay line.

It has two transitions:
- LAST_COEF takes LOAD to HOLD on the capture into the final slot.
- TABLE_READY takes HOLD to RUN when `table_ready` is high.

RUN is left only through reset.

Top module: `tap_bit_buffer`

## Requirements
- R1: Reset clears every row to zero and puts the block into LOAD. In that state `tap_bits`, `msb_flag` and `coef_full` are 0, and `coef_rd` reads 0 for every slot.
- R2: In LOAD, each clock edge with `coef_enable` high stores `din[COEF_W-1:0]` into the next slot, filling slots 0 to TAPS-1 in order. Edges with `coef_enable` low store nothing. `coef_rd` combinationally shows the slot selected by `coef_sel`.
- R3: `coef_full` is high for exactly one cycle, namely the cycle after the edge that stores the final coefficient.
- R4: In HOLD, `coef_enable`, `din` and `sample_valid` have no effect, and every stored coefficient stays readable unchanged until `table_ready`.
- R5: `table_ready` high in HOLD moves the block to RUN at the next edge. At that same edge every row is cleared, so the first RUN frame presents all-zero bits, and its first cycle presents bit 0.
- R6: In RUN, the frame cycle with index b (0 to SAMP_W-1) drives `tap_bits[t]` with bit b of the sample in row t, starting from the least significant bit. `msb_flag` is high only in the cycle with b = SAMP_W-1, so it is high one cycle in every SAMP_W.
- R7: At the edge that ends the MSB cycle, if a sample is pending, row 0 takes the new sample, row t takes the old row t-1, and the old row TAPS-1 is dropped. The next frame then presents these rows from bit 0.
- R8: A `sample_valid` that arrives mid-frame is held and applied only at the frame boundary, and a later valid in the same frame replaces an earlier one. A frame that has no valid leaves every row unchanged for the next frame.
- R9: Outside RUN, `tap_bits` and `msb_flag` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | PORT_W | Shared input for samples and coefficients |
| coef_enable | input | 1 | Writes din into the next coefficient slot |
| sample_valid | input | 1 | Offers din[SAMP_W-1:0] as a new sample |
| table_ready | input | 1 | Table initializer finished; start serial operation |
| coef_sel | input | IDX_W | Coefficient slot to read |
| coef_rd | output | COEF_W | Coefficient in the selected slot |
| coef_full | output | 1 | One-cycle pulse after the final coefficient is stored |
| tap_bits | output | TAPS | Current bit of each tap's sample |
| msb_flag | output | 1 | Current bits are the sample sign bits |

## Verification
`coef_rd` is combinational and is checked in the cycle after the storing edge. `coef_full` is due in the cycle after the edge that stores the final coefficient, and it must be low again one cycle later. The first RUN cycle follows the edge that samples `table_ready`. A sample accepted at a boundary edge appears in tap 0 in the next cycle, as bit 0. The bench drives every input just after a falling edge and compares outputs at the following falling edge. It locks onto the frame by `msb_flag`, then steps the bit index once per cycle and compares against its own four-entry history of the samples it sent.

// File: rtl/tbb_pkg.sv
package tbb_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } buf_state_e;

endpackage

// File: rtl/tbb_ctrl.sv
module tbb_ctrl
    import tbb_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int SAMP_W = 8,
    parameter int PORT_W = 10,
    localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1,
    localparam int BIT_W = (SAMP_W > 1) ? $clog2(SAMP_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] din,
    input  logic              coef_enable,
    input  logic              sample_valid,
    input  logic              table_ready,
    output buf_state_e        state,
    output logic              load_en,
    output logic [IDX_W-1:0]  load_idx,
    output logic              clear,
    output logic              rot_en,
    output logic              push_en,
    output logic [SAMP_W-1:0] push_data,
    output logic              msb_flag,
    output logic              coef_full
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(TAPS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SAMP_W - 1);

    buf_state_e        state_nx;
    logic [BIT_W-1:0]  bit_idx;
    logic              pend_v;
    logic [SAMP_W-1:0] pend_d;
    logic              at_msb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    // transitions: LAST_COEF, TABLE_READY
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: if (coef_enable && load_idx == LAST_SLOT) state_nx = ST_HOLD;
            ST_HOLD: if (table_ready) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
            default: state_nx = ST_LOAD;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load_en   = 1'b0;
        clear     = 1'b0;
        rot_en    = 1'b0;
        at_msb    = 1'b0;
        unique case (state)
            ST_LOAD: load_en = coef_enable;
            ST_HOLD: clear   = table_ready;
            ST_RUN: begin
                rot_en = 1'b1;
                at_msb = (bit_idx == LAST_BIT);
            end
            default: ;
        endcase
        push_en   = at_msb && (sample_valid || pend_v);
        push_data = sample_valid ? din[SAMP_W-1:0] : pend_d;
        msb_flag  = at_msb;
    end

    // coefficient slot counter
    always_ff @(posedge clk) begin
        if (!rst_n)       load_idx <= '0;
        else if (load_en) load_idx <= (load_idx == LAST_SLOT) ? '0 : load_idx + 1'b1;
    end

    // bit position within the frame
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RUN) bit_idx <= '0;
        else if (at_msb)               bit_idx <= '0;
        else                           bit_idx <= bit_idx + 1'b1;
    end

    // sample held until the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RUN) begin
            pend_v <= 1'b0;
            pend_d <= '0;
        end else if (at_msb) begin
            pend_v <= 1'b0;
        end else if (sample_valid) begin
            pend_v <= 1'b1;
            pend_d <= din[SAMP_W-1:0];
        end
    end

    // one-cycle pulse after the final coefficient
    always_ff @(posedge clk) begin
        if (!rst_n) coef_full <= 1'b0;
        else        coef_full <= (state == ST_LOAD) && (state_nx == ST_HOLD);
    end

    assert_full_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_full |=> !coef_full);

    assert_full_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_full |-> state == ST_HOLD);

    assert_enter_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && table_ready) |=> (state == ST_RUN && !msb_flag));

    generate
        if (SAMP_W > 1) begin : g_msb_gap
            assert_msb_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                msb_flag |=> !msb_flag);
        end
    endgenerate

endmodule

// File: rtl/tbb_rows.sv
module tbb_rows #(
    parameter int TAPS   = 4,
    parameter int SAMP_W = 8,
    parameter int ROW_W  = 10,
    localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       load_en,
    input  logic [IDX_W-1:0]           load_idx,
    input  logic [ROW_W-1:0]           load_data,
    input  logic                       rot_en,
    input  logic                       push_en,
    input  logic [SAMP_W-1:0]          push_data,
    output logic [TAPS-1:0][ROW_W-1:0] rows
);

    // rotate the sample field right by one bit
    function automatic logic [ROW_W-1:0] rot1(input logic [ROW_W-1:0] x);
        logic [ROW_W-1:0] y;
        y = x;
        y[SAMP_W-1:0] = {x[0], x[SAMP_W-1:1]};
        return y;
    endfunction

    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_row
            logic [ROW_W-1:0] shift_src;
            if (t == 0) begin : g_top
                assign shift_src = {{(ROW_W-SAMP_W){1'b0}}, push_data};
            end else begin : g_lower
                assign shift_src = rot1(rows[t-1]);
            end

            always_ff @(posedge clk) begin
                if (!rst_n || clear)                       rows[t] <= '0;
                else if (load_en && int'(load_idx) == t)   rows[t] <= load_data;
                else if (rot_en && push_en)                rows[t] <= shift_src;
                else if (rot_en)                           rows[t] <= rot1(rows[t]);
            end
        end
    endgenerate

    assert_clear_rows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> rows == '0);

    assert_push_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_en && push_en && !clear) |=> rows[0][SAMP_W-1:0] == $past(push_data));

endmodule

// File: rtl/tap_bit_buffer.sv
module tap_bit_buffer
    import tbb_pkg::*;
#(
    parameter int TAPS   = 4,
    parameter int SAMP_W = 8,
    parameter int COEF_W = 10,
    localparam int PORT_W = (SAMP_W > COEF_W) ? SAMP_W : COEF_W,
    localparam int IDX_W  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] din,
    input  logic              coef_enable,
    input  logic              sample_valid,
    input  logic              table_ready,
    input  logic [IDX_W-1:0]  coef_sel,
    output logic [COEF_W-1:0] coef_rd,
    output logic              coef_full,
    output logic [TAPS-1:0]   tap_bits,
    output logic              msb_flag
);

    buf_state_e                 state;
    logic                       load_en;
    logic [IDX_W-1:0]           load_idx;
    logic                       clear;
    logic                       rot_en;
    logic                       push_en;
    logic [SAMP_W-1:0]          push_data;
    logic [TAPS-1:0][PORT_W-1:0] rows;

    tbb_ctrl #(.TAPS(TAPS), .SAMP_W(SAMP_W), .PORT_W(PORT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .din          (din),
        .coef_enable  (coef_enable),
        .sample_valid (sample_valid),
        .table_ready  (table_ready),
        .state        (state),
        .load_en      (load_en),
        .load_idx     (load_idx),
        .clear        (clear),
        .rot_en       (rot_en),
        .push_en      (push_en),
        .push_data    (push_data),
        .msb_flag     (msb_flag),
        .coef_full    (coef_full)
    );

    tbb_rows #(.TAPS(TAPS), .SAMP_W(SAMP_W), .ROW_W(PORT_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .load_en   (load_en),
        .load_idx  (load_idx),
        .load_data (din),
        .rot_en    (rot_en),
        .push_en   (push_en),
        .push_data (push_data),
        .rows      (rows)
    );

    // coefficient read port
    always_comb begin
        coef_rd = '0;
        for (int t = 0; t < TAPS; t++) begin
            if (int'(coef_sel) == t) coef_rd = rows[t][COEF_W-1:0];
        end
    end

    // serial bit per tap, gated outside RUN
    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            assign tap_bits[t] = (state == ST_RUN) & rows[t][0];
        end
    endgenerate

    assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> $stable(rows));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> (tap_bits == '0 && !msb_flag));

endmodule

// File: tb/test_tap_bit_buffer.sv
`timescale 1ns/1ps
module test_tap_bit_buffer;

    localparam int TAPS = 4, SAMP_W = 8, COEF_W = 10, PORT_W = 10;
    localparam logic [9:0] COEFS [4] = '{10'h3FF, 10'h155, 10'h2AA, 10'h001};
    localparam logic [7:0] SAMPLES [6] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h3C, 8'h5A};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PORT_W-1:0] din = '0;
    logic              coef_enable = 1'b0;
    logic              sample_valid = 1'b0;
    logic              table_ready = 1'b0;
    logic [1:0]        coef_sel = '0;
    logic [COEF_W-1:0] coef_rd;
    logic              coef_full;
    logic [TAPS-1:0]   tap_bits;
    logic              msb_flag;

    int n_run = 0, n_fail = 0, cycles = 0;
    bit finished = 0;
    logic [7:0] hist [TAPS];

    always #5 clk = ~clk;

    tap_bit_buffer #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W)) i_tap_bit_buffer (
        .clk(clk), .rst_n(rst_n), .din(din), .coef_enable(coef_enable),
        .sample_valid(sample_valid), .table_ready(table_ready), .coef_sel(coef_sel),
        .coef_rd(coef_rd), .coef_full(coef_full), .tap_bits(tap_bits), .msb_flag(msb_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [TAPS-1:0] exp_bits(input int b);
        logic [TAPS-1:0] v;
        for (int t = 0; t < TAPS; t++) v[t] = hist[t][b];
        return v;
    endfunction

    task automatic push_hist(input logic [7:0] s);
        for (int t = TAPS-1; t > 0; t--) hist[t] = hist[t-1];
        hist[0] = s;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        int cnt;
        for (int t = 0; t < TAPS; t++) hist[t] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tap_bits == 0 && !msb_flag && !coef_full, "R1", {tap_bits, msb_flag, coef_full}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < TAPS; k++) begin
            coef_sel = 2'(k);
            #1 check(coef_rd == 0, "R1", coef_rd, 0);
        end

        // R2 coefficient loading with a gap after slot 1
        for (int k = 0; k < TAPS; k++) begin
            @(negedge clk);
            check(!coef_full, "R3", coef_full, 0);
            coef_enable = 1'b1; din = COEFS[k];
            if (k == 2) begin
                coef_enable = 1'b0; din = 10'h0C3;
                @(negedge clk);
                coef_enable = 1'b1; din = COEFS[k];
            end
        end
        @(negedge clk);
        coef_enable = 1'b0; din = '0;
        check(coef_full, "R3", coef_full, 1);
        @(negedge clk);
        check(!coef_full, "R3", coef_full, 0);
        for (int k = 0; k < TAPS; k++) begin
            coef_sel = 2'(k);
            #1 check(coef_rd == COEFS[k], "R2", coef_rd, COEFS[k]);
        end

        // R4 writes and samples ignored in HOLD
        coef_enable = 1'b1; sample_valid = 1'b1; din = 10'h2C7;
        repeat (3) @(negedge clk);
        coef_enable = 1'b0; sample_valid = 1'b0; din = '0;
        check(tap_bits == 0 && !msb_flag, "R9", {tap_bits, msb_flag}, 0);
        check(!coef_full, "R4", coef_full, 0);
        for (int k = 0; k < TAPS; k++) begin
            coef_sel = 2'(k);
            #1 check(coef_rd == COEFS[k], "R4", coef_rd, COEFS[k]);
        end

        // R5 start of RUN
        table_ready = 1'b1;
        @(negedge clk);
        table_ready = 1'b0;
        check(tap_bits == 0 && !msb_flag, "R5", {tap_bits, msb_flag}, 0);
        cnt = 0;
        while (!msb_flag) begin
            @(negedge clk);
            cnt++;
            check(tap_bits == 0, "R5", tap_bits, 0);
        end
        check(cnt == SAMP_W-1, "R6", cnt, SAMP_W-1);

        // R6 R7 stimulus table, one sample per boundary
        for (int i = 0; i < 6; i++) begin
            din = {2'b00, SAMPLES[i]}; sample_valid = 1'b1;
            push_hist(SAMPLES[i]);
            for (int b = 0; b < SAMP_W; b++) begin
                @(negedge clk);
                sample_valid = 1'b0;
                check(tap_bits == exp_bits(b), "R7", tap_bits, exp_bits(b));
                check(msb_flag == (b == SAMP_W-1), "R6", msb_flag, b == SAMP_W-1);
            end
        end

        // R8 no sample: rows recirculate; two mid-frame valids, later wins
        for (int b = 0; b < SAMP_W; b++) begin
            @(negedge clk);
            sample_valid = 1'b0;
            check(tap_bits == exp_bits(b), "R8", tap_bits, exp_bits(b));
            if (b == 2) begin din = 10'h0C3; sample_valid = 1'b1; end
            if (b == 5) begin din = 10'h096; sample_valid = 1'b1; end
        end
        push_hist(8'h96);
        for (int b = 0; b < SAMP_W; b++) begin
            @(negedge clk);
            check(tap_bits == exp_bits(b), "R8", tap_bits, exp_bits(b));
        end

        // R1 reset mid-run returns to LOAD
        rst_n = 1'b0;
        @(negedge clk);
        check(tap_bits == 0 && !msb_flag, "R1", {tap_bits, msb_flag}, 0);
        coef_sel = 2'd0;
        #1 check(coef_rd == 0, "R1", coef_rd, 0);
        rst_n = 1'b1;
        coef_enable = 1'b1; din = 10'h1A6;
        @(negedge clk);
        coef_enable = 1'b0;
        check(coef_rd == 10'h1A6, "R2", coef_rd, 10'h1A6);

        finish_run();
    end

endmodule